// File: doc/BRIEF.md
# Sliding-Window Seed Match Engine

The engine scans a stream of database symbol chains and looks for exact hits against a table of short candidate words. The candidates are a four-symbol seed and its likely mutated forms. Each accepted symbol enters a delay line. The oldest four slots of the line form the window, and all enabled candidates are compared against that window at once. When a window hits, the engine reports the stream position of the window and the index of the matching candidate. It then runs an ungapped extension, one symbol per cycle, comparing the database symbols after the window with a loaded sample continuation.

The delay line holds the window and a short lookahead of following symbols. Extension reads from this lookahead, so the input stream stays still while an extension is running. When a chain ends and nothing follows it, the engine pushes empty slots through the line. This brings the tail windows of the chain into view without waiting for more input. Candidates, the continuation, its length and the mismatch tolerance are loaded through plain write pins while the stream is idle.

Input stream rules: a symbol transfers on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is low while a hit at the current window is still unreported, while an extension runs, and while its result waits. Output stream rules: a result is offered with `m_valid` and is held unchanged until a cycle with `m_ready` high.

Top module: `seed_match_engine`

## Requirements
- R1: A window is valid only when its four slots hold four consecutive symbols of one chain. No hit is reported for a window that spans a chain end (`s_last`) or for a chain shorter than four symbols.
- R2: Every window position of every chain is checked, so overlapping hits at consecutive positions are all reported, in stream order.
- R3: When several enabled candidates equal the window, the lowest index is reported in `m_cand`. A disabled entry (loaded with `cand_en`=0) never hits. A candidate word holds stream symbol i (i=0 earliest) at bits [5i+4:5i].
- R4: Extension compares database symbol j after the window with continuation entry j. A mismatch is tolerated and counted while the count is below `mm_limit`. The mismatch that would exceed `mm_limit` stops the extension and is not counted in either `m_len` or `m_mism`.
- R5: Extension also stops when j reaches `cont_len`, when j reaches the lookahead depth (8), or when the chain ends. `m_len` is the number of symbols passed, including tolerated mismatches.
- R6: `s_ready` is low from a hit until its result has been accepted, so the window position does not move during extension.
- R7: A result with `m_valid` high and `m_ready` low is held with all fields unchanged in the next cycle.
- R8: After reset, `s_ready` is high and `m_valid` is low.
- R9: `m_pos` is the index of the first window symbol, counting from 0 over all symbols accepted since reset, across chains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cand_we | input | 1 | Write one candidate table entry |
| cand_idx | input | 6 | Entry index (indexes of 50 and above are ignored) |
| cand_word | input | 20 | Four-symbol candidate word |
| cand_en | input | 1 | Entry enabled when 1 |
| cont_we | input | 1 | Write one continuation symbol |
| cont_addr | input | 3 | Continuation entry index |
| cont_sym | input | 5 | Continuation symbol |
| cont_len | input | 4 | Number of valid continuation symbols |
| mm_limit | input | 4 | Mismatches tolerated during extension |
| s_valid | input | 1 | Input symbol valid |
| s_ready | output | 1 | Engine accepts a symbol |
| s_sym | input | 5 | Database symbol |
| s_last | input | 1 | Symbol is the last of its chain |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Result consumer ready |
| m_pos | output | 16 | Stream position of the hit window |
| m_cand | output | 6 | Matching candidate index |
| m_len | output | 4 | Extension length |
| m_mism | output | 4 | Mismatches inside the extension |

## Verification
The hardest case to reach is an extension that is cut short by a chain end. In that case the lookahead already holds symbols of the next chain, which must not be compared. A second hard case is a hit in the last window of a chain, which is reached only after the engine has drained empty slots itself. The stimulus sends chains back to back, with seeds placed near their ends, and leaves the stream idle after the final chain. It also holds the result port back in an irregular pattern while overlapping hits queue up.

// File: rtl/smx_pkg.sv
package smx_pkg;
  typedef enum logic [1:0] {EX_IDLE, EX_RUN, EX_OUT} ext_state_t;
endpackage

// File: rtl/smx_window.sv
module smx_window #(
  parameter int SYM_W = 5,
  parameter int WIN   = 4,
  parameter int LOOK  = 8,
  parameter int POS_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            shift,
  input  logic                            in_take,
  input  logic [SYM_W-1:0]                in_sym,
  input  logic                            in_last,
  output logic                            win_ok,
  output logic [WIN*SYM_W-1:0]            win_word,
  output logic [POS_W-1:0]                win_pos,
  output logic [LOOK-1:0][SYM_W-1:0]      look_sym,
  output logic [LOOK-1:0]                 look_vld,
  output logic [LOOK-1:0]                 look_brk,
  output logic                            drain_req
);
  localparam int D = WIN + LOOK;

  logic [SYM_W-1:0] sym_q [D];
  logic [POS_W-1:0] pos_q [D];
  logic [D-1:0]     vld_q;
  logic [D-1:0]     last_q;
  logic [POS_W-1:0] ctr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      last_q <= '0;
      ctr_q  <= '0;
      for (int k = 0; k < D; k++) begin
        sym_q[k] <= '0;
        pos_q[k] <= '0;
      end
    end else if (shift) begin
      for (int k = 0; k < D-1; k++) begin
        sym_q[k]  <= sym_q[k+1];
        pos_q[k]  <= pos_q[k+1];
        vld_q[k]  <= vld_q[k+1];
        last_q[k] <= last_q[k+1];
      end
      sym_q[D-1]  <= in_sym;
      pos_q[D-1]  <= ctr_q;
      vld_q[D-1]  <= in_take;
      last_q[D-1] <= in_take & in_last;
      if (in_take) ctr_q <= ctr_q + 1'b1;
    end
  end

  // slot 0 is the oldest symbol and the first symbol of the window
  assign win_ok  = (&vld_q[WIN-1:0]) && !(|last_q[WIN-2:0]);
  assign win_pos = pos_q[0];

  for (genvar w = 0; w < WIN; w++) begin : g_win
    assign win_word[w*SYM_W +: SYM_W] = sym_q[w];
  end

  for (genvar j = 0; j < LOOK; j++) begin : g_look
    assign look_sym[j] = sym_q[WIN+j];
    assign look_vld[j] = vld_q[WIN+j];
    assign look_brk[j] = last_q[WIN+j-1];
  end

  // drain with empty slots only when the newest stored symbol closes a chain
  always_comb begin
    drain_req = 1'b0;
    for (int k = 0; k < D; k++) begin
      if (vld_q[k]) drain_req = last_q[k] && (k >= WIN);
    end
  end

  a_r1_window_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    win_ok |-> (pos_q[WIN-1] == pos_q[0] + POS_W'(WIN-1)));

  a_r9_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q[0] && vld_q[1] && !last_q[0]) |-> (pos_q[1] == pos_q[0] + 1'b1));
endmodule

// File: rtl/smx_cand_table.sv
module smx_cand_table #(
  parameter int SYM_W = 5,
  parameter int WIN   = 4,
  parameter int NCAND = 50,
  parameter int CIW   = $clog2(NCAND)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CIW-1:0]       wr_idx,
  input  logic [WIN*SYM_W-1:0] wr_word,
  input  logic                 wr_keep,
  input  logic [WIN*SYM_W-1:0] key,
  output logic                 hit,
  output logic [CIW-1:0]       hit_idx
);
  localparam logic [CIW:0] NC_L = (CIW+1)'(NCAND);

  logic [WIN*SYM_W-1:0] word_q [NCAND];
  logic [NCAND-1:0]     en_q;
  logic [NCAND-1:0]     match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int c = 0; c < NCAND; c++) word_q[c] <= '0;
    end else if (wr_en && ({1'b0, wr_idx} < NC_L)) begin
      word_q[wr_idx] <= wr_word;
      en_q[wr_idx]   <= wr_keep;
    end
  end

  for (genvar c = 0; c < NCAND; c++) begin : g_cmp
    assign match[c] = en_q[c] && (word_q[c] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int c = NCAND-1; c >= 0; c--) begin
      if (match[c]) hit_idx = CIW'(c);
    end
  end
  assign hit = |match;

  a_r3_lowest_index: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (match[hit_idx] &&
             ((match & ((NCAND'(1) << hit_idx) - NCAND'(1))) == '0)));
endmodule

// File: rtl/smx_extender.sv
module smx_extender
  import smx_pkg::*;
#(
  parameter int SYM_W = 5,
  parameter int LOOK  = 8,
  parameter int POS_W = 16,
  parameter int CIW   = 6,
  parameter int LIW   = $clog2(LOOK),
  parameter int LJW   = $clog2(LOOK+1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cont_we,
  input  logic [LIW-1:0]             cont_addr,
  input  logic [SYM_W-1:0]           cont_sym,
  input  logic [LJW-1:0]             cont_len,
  input  logic [LJW-1:0]             mm_limit,
  input  logic                       start,
  input  logic [POS_W-1:0]           start_pos,
  input  logic [CIW-1:0]             start_cand,
  input  logic [LOOK-1:0][SYM_W-1:0] look_sym,
  input  logic [LOOK-1:0]            look_vld,
  input  logic [LOOK-1:0]            look_brk,
  output logic                       busy,
  output logic                       m_valid,
  input  logic                       m_ready,
  output logic [POS_W-1:0]           m_pos,
  output logic [CIW-1:0]             m_cand,
  output logic [LJW-1:0]             m_len,
  output logic [LJW-1:0]             m_mism
);
  ext_state_t       st_q;
  logic [SYM_W-1:0] cont_q [LOOK];
  logic [LJW-1:0]   j_q, mm_q;
  logic [POS_W-1:0] pos_q;
  logic [CIW-1:0]   cand_q;
  logic [LIW-1:0]   jx;
  logic             neq, stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < LOOK; k++) cont_q[k] <= '0;
    end else if (cont_we) begin
      cont_q[cont_addr] <= cont_sym;
    end
  end

  assign jx  = j_q[LIW-1:0];
  assign neq = (look_sym[jx] != cont_q[jx]);

  always_comb begin
    if ((j_q == cont_len) || (j_q == LJW'(LOOK))) stop = 1'b1;
    else stop = !look_vld[jx] || look_brk[jx] || (neq && (mm_q == mm_limit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EX_IDLE;
      j_q    <= '0;
      mm_q   <= '0;
      pos_q  <= '0;
      cand_q <= '0;
    end else begin
      unique case (st_q)
        EX_IDLE: if (start) begin
          st_q   <= EX_RUN;
          j_q    <= '0;
          mm_q   <= '0;
          pos_q  <= start_pos;
          cand_q <= start_cand;
        end
        EX_RUN: if (stop) begin
          st_q <= EX_OUT;
        end else begin
          j_q  <= j_q + 1'b1;
          mm_q <= mm_q + LJW'(neq);
        end
        EX_OUT: if (m_ready) st_q <= EX_IDLE;
        default: st_q <= EX_IDLE;
      endcase
    end
  end

  assign busy    = (st_q != EX_IDLE);
  assign m_valid = (st_q == EX_OUT);
  assign m_pos   = pos_q;
  assign m_cand  = cand_q;
  assign m_len   = j_q;
  assign m_mism  = mm_q;

  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_pos) && $stable(m_cand) &&
                               $stable(m_len) && $stable(m_mism)));

  a_r4_mism_bound: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> ((m_mism <= mm_limit) && (m_mism <= m_len)));

  a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> ((m_len <= cont_len) && (m_len <= LJW'(LOOK))));
endmodule

// File: rtl/seed_match_engine.sv
module seed_match_engine #(
  parameter int SYM_W = 5,
  parameter int WIN   = 4,
  parameter int LOOK  = 8,
  parameter int NCAND = 50,
  parameter int POS_W = 16,
  parameter int CIW   = $clog2(NCAND),
  parameter int LIW   = $clog2(LOOK),
  parameter int LJW   = $clog2(LOOK+1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cand_we,
  input  logic [CIW-1:0]       cand_idx,
  input  logic [WIN*SYM_W-1:0] cand_word,
  input  logic                 cand_en,
  input  logic                 cont_we,
  input  logic [LIW-1:0]       cont_addr,
  input  logic [SYM_W-1:0]     cont_sym,
  input  logic [LJW-1:0]       cont_len,
  input  logic [LJW-1:0]       mm_limit,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [SYM_W-1:0]     s_sym,
  input  logic                 s_last,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [POS_W-1:0]     m_pos,
  output logic [CIW-1:0]       m_cand,
  output logic [LJW-1:0]       m_len,
  output logic [LJW-1:0]       m_mism
);
  logic                       win_ok, drain_req, tab_hit, win_hit;
  logic [WIN*SYM_W-1:0]       win_word;
  logic [POS_W-1:0]           win_pos;
  logic [LOOK-1:0][SYM_W-1:0] look_sym;
  logic [LOOK-1:0]            look_vld, look_brk;
  logic [CIW-1:0]             tab_idx;
  logic                       ext_busy, start, shift, take, chk_q;

  assign win_hit = win_ok && tab_hit;
  assign start   = win_hit && !chk_q && !ext_busy;
  assign s_ready = !ext_busy && !(win_hit && !chk_q);
  assign take    = s_valid && s_ready;
  assign shift   = s_ready && (s_valid || drain_req);

  // marks that the window now in the oldest slots has already been reported
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     chk_q <= 1'b0;
    else if (shift) chk_q <= 1'b0;
    else if (start) chk_q <= 1'b1;
  end

  smx_window #(.SYM_W(SYM_W), .WIN(WIN), .LOOK(LOOK), .POS_W(POS_W)) u_win (
    .clk(clk), .rst_n(rst_n), .shift(shift), .in_take(take), .in_sym(s_sym),
    .in_last(s_last), .win_ok(win_ok), .win_word(win_word), .win_pos(win_pos),
    .look_sym(look_sym), .look_vld(look_vld), .look_brk(look_brk),
    .drain_req(drain_req)
  );

  smx_cand_table #(.SYM_W(SYM_W), .WIN(WIN), .NCAND(NCAND), .CIW(CIW)) u_tab (
    .clk(clk), .rst_n(rst_n), .wr_en(cand_we), .wr_idx(cand_idx),
    .wr_word(cand_word), .wr_keep(cand_en), .key(win_word),
    .hit(tab_hit), .hit_idx(tab_idx)
  );

  smx_extender #(.SYM_W(SYM_W), .LOOK(LOOK), .POS_W(POS_W), .CIW(CIW),
                 .LIW(LIW), .LJW(LJW)) u_ext (
    .clk(clk), .rst_n(rst_n), .cont_we(cont_we), .cont_addr(cont_addr),
    .cont_sym(cont_sym), .cont_len(cont_len), .mm_limit(mm_limit),
    .start(start), .start_pos(win_pos), .start_cand(tab_idx),
    .look_sym(look_sym), .look_vld(look_vld), .look_brk(look_brk),
    .busy(ext_busy), .m_valid(m_valid), .m_ready(m_ready), .m_pos(m_pos),
    .m_cand(m_cand), .m_len(m_len), .m_mism(m_mism)
  );

  a_r6_window_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ext_busy |=> $stable(win_pos));
endmodule

// File: tb/tb_seed_match_engine.sv
module tb_seed_match_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NCAND = 50;
  localparam int LOOK  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cand_we = 0, cand_en = 0, cont_we = 0;
  logic [5:0] cand_idx = '0;
  logic [19:0] cand_word = '0;
  logic [2:0] cont_addr = '0;
  logic [4:0] cont_sym = '0, s_sym = '0;
  logic [3:0] cont_len = '0, mm_limit = '0;
  logic s_valid = 0, s_last = 0, m_ready = 1;
  logic s_ready, m_valid;
  logic [15:0] m_pos;
  logic [5:0] m_cand;
  logic [3:0] m_len, m_mism;

  seed_match_engine dut (
    .clk(clk), .rst_n(rst_n), .cand_we(cand_we), .cand_idx(cand_idx),
    .cand_word(cand_word), .cand_en(cand_en), .cont_we(cont_we),
    .cont_addr(cont_addr), .cont_sym(cont_sym), .cont_len(cont_len),
    .mm_limit(mm_limit), .s_valid(s_valid), .s_ready(s_ready), .s_sym(s_sym),
    .s_last(s_last), .m_valid(m_valid), .m_ready(m_ready), .m_pos(m_pos),
    .m_cand(m_cand), .m_len(m_len), .m_mism(m_mism)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  bit bp_mode = 0;
  int cyc = 0, r6_viol = 0, r7_viol = 0;
  int gpos = 0;

  int got_pos[$], got_cand[$], got_len[$], got_mm[$];
  int exp_pos[$], exp_cand[$], exp_len[$], exp_mm[$];

  logic [19:0] bw [NCAND];
  bit          ben [NCAND];
  logic [4:0]  bcont [LOOK];
  logic [4:0]  cb [64];
  int          cl = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [4:0] sy(byte c);
    return 5'(c - 8'd64);
  endfunction

  function automatic logic [19:0] w4(string s);
    return {sy(s[3]), sy(s[2]), sy(s[1]), sy(s[0])};
  endfunction

  // output monitor: drives m_ready and records accepted results
  logic        hold_prev = 0;
  logic [15:0] pp; logic [5:0] pc; logic [3:0] pl, pm;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (hold_prev && rst_n) begin
        if (!(m_valid && m_pos == pp && m_cand == pc && m_len == pl && m_mism == pm))
          r7_viol++;
      end
      m_ready = bp_mode ? ((cyc % 3) == 0) : 1'b1;
      if (rst_n && m_valid && s_ready) r6_viol++;
      if (rst_n && m_valid && m_ready) begin
        got_pos.push_back(int'(m_pos));
        got_cand.push_back(int'(m_cand));
        got_len.push_back(int'(m_len));
        got_mm.push_back(int'(m_mism));
      end
      hold_prev = rst_n && m_valid && !m_ready;
      pp = m_pos; pc = m_cand; pl = m_len; pm = m_mism;
    end
  end

  task automatic load_cand(int i, string s, bit en);
    @(negedge clk);
    cand_we = 1; cand_idx = 6'(i); cand_word = w4(s); cand_en = en;
    @(negedge clk);
    cand_we = 0;
    bw[i] = w4(s); ben[i] = en;
  endtask

  task automatic clear_cands();
    for (int i = 0; i < NCAND; i++) if (ben[i]) load_cand(i, "AAAA", 0);
  endtask

  task automatic load_cont(string s, int len, int lim);
    for (int i = 0; i < LOOK; i++) begin
      @(negedge clk);
      cont_we = 1; cont_addr = 3'(i); cont_sym = sy(s[i]);
      bcont[i] = sy(s[i]);
    end
    @(negedge clk);
    cont_we = 0; cont_len = 4'(len); mm_limit = 4'(lim);
  endtask

  task automatic send_sym(logic [4:0] s, logic l);
    @(negedge clk);
    s_valid = 1; s_sym = s; s_last = l;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    gpos++;
  endtask

  task automatic send_chain(string s);
    cl = s.len();
    for (int i = 0; i < cl; i++) cb[i] = sy(s[i]);
    for (int i = 0; i < cl; i++) send_sym(cb[i], i == cl-1);
    @(negedge clk);
    s_valid = 0; s_last = 0;
  endtask

  // independent reference of the hit and extension rules
  task automatic model_chain(int base);
    for (int p = 0; p + 4 <= cl; p++) begin
      int ci = -1;
      for (int c = 0; c < NCAND; c++) begin
        if (ci < 0 && ben[c] && bw[c] == {cb[p+3], cb[p+2], cb[p+1], cb[p]}) ci = c;
      end
      if (ci >= 0) begin
        int j = 0, mm = 0;
        while (j < int'(cont_len) && j < LOOK && p + 4 + j < cl) begin
          if (cb[p+4+j] != bcont[j]) begin
            if (mm == int'(mm_limit)) break;
            mm++;
          end
          j++;
        end
        exp_pos.push_back(base + p); exp_cand.push_back(ci);
        exp_len.push_back(j); exp_mm.push_back(mm);
      end
    end
  endtask

  task automatic start_run();
    got_pos.delete(); got_cand.delete(); got_len.delete(); got_mm.delete();
    exp_pos.delete(); exp_cand.delete(); exp_len.delete(); exp_mm.delete();
  endtask

  task automatic run_chain(string s);
    int base = gpos;
    send_chain(s);
    model_chain(base);
  endtask

  task automatic finish_run(string req);
    repeat (200) @(negedge clk);
    chk(got_pos.size() == exp_pos.size(), req, "result count", got_pos.size(), exp_pos.size());
    for (int i = 0; i < exp_pos.size() && i < got_pos.size(); i++) begin
      chk(got_pos[i] == exp_pos[i], req, "m_pos", got_pos[i], exp_pos[i]);
      chk(got_cand[i] == exp_cand[i], req, "m_cand", got_cand[i], exp_cand[i]);
      chk(got_len[i] == exp_len[i], req, "m_len", got_len[i], exp_len[i]);
      chk(got_mm[i] == exp_mm[i], req, "m_mism", got_mm[i], exp_mm[i]);
    end
  endtask

  task automatic t_reset();
    chk(s_ready == 1'b1, "R8", "s_ready after reset", int'(s_ready), 1);
    chk(m_valid == 1'b0, "R8", "m_valid after reset", int'(m_valid), 0);
  endtask

  task automatic t_basic();
    int base;
    load_cand(3, "BBCF", 1);
    load_cand(10, "BECF", 1);
    load_cont("EADGHIKL", 8, 1);
    start_run();
    base = gpos;
    run_chain("XXBECFEADQHIKLMN");
    repeat (100) @(negedge clk);
    chk(got_pos.size() > 0 && got_pos[0] == base + 2, "R9", "first hit position",
        got_pos.size() > 0 ? got_pos[0] : -1, base + 2);
    finish_run("R9");
    clear_cands();
  endtask

  task automatic t_priority();
    load_cand(2, "AAAB", 0);
    load_cand(7, "AAAB", 1);
    load_cand(5, "AAAB", 1);
    load_cont("CCCCCCCC", 3, 0);
    start_run();
    run_chain("QAAABCCX");
    finish_run("R3");
    chk(got_cand.size() == 1 && got_cand[0] == 5, "R3", "lowest enabled index",
        got_cand.size() == 1 ? got_cand[0] : -1, 5);
    clear_cands();
  endtask

  task automatic t_overlap();
    load_cand(0, "AAAA", 1);
    load_cont("AAAAAAAA", 8, 0);
    start_run();
    run_chain("AAAAAAAAAAAAAAA");
    finish_run("R2");
    chk(got_pos.size() == 12, "R2", "overlapping hit count", got_pos.size(), 12);
  endtask

  task automatic t_backpressure();
    bp_mode = 1;
    start_run();
    run_chain("AAAAAAAAAB");
    finish_run("R7");
    bp_mode = 0;
    chk(r7_viol == 0, "R7", "held result changed", r7_viol, 0);
    clear_cands();
  endtask

  task automatic t_boundary();
    load_cand(4, "ABCD", 1);
    load_cont("EFGHIJKL", 8, 2);
    start_run();
    run_chain("QQAB");
    run_chain("CDQQ");
    run_chain("ABC");
    finish_run("R1");
    chk(got_pos.size() == 0, "R1", "hits across chain end", got_pos.size(), 0);
    start_run();
    run_chain("ZABCD");
    run_chain("EFGH");
    finish_run("R5");
    chk(got_len.size() == 1 && got_len[0] == 0, "R5", "length at chain end",
        got_len.size() == 1 ? got_len[0] : -1, 0);
    clear_cands();
  endtask

  task automatic t_mism();
    load_cand(9, "KLMN", 1);
    for (int lim = 0; lim < 4; lim++) begin
      load_cont("ABCDEFGH", 8, lim);
      start_run();
      run_chain("KLMNAXCXEXGH");
      run_chain("KLMNABCDEFGHIJ");
      finish_run("R4");
    end
  endtask

  task automatic t_contlen();
    load_cont("ABCDEFGH", 2, 1);
    start_run();
    run_chain("KLMNABCDEF");
    finish_run("R5");
    load_cont("ABCDEFGH", 0, 1);
    start_run();
    run_chain("KLMNABCD");
    finish_run("R5");
    chk(got_len.size() == 1 && got_len[0] == 0, "R5", "zero continuation",
        got_len.size() == 1 ? got_len[0] : -1, 0);
    clear_cands();
  endtask

  initial begin
    for (int i = 0; i < NCAND; i++) begin bw[i] = '0; ben[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_priority();
    t_overlap();
    t_backpressure();
    t_boundary();
    t_mism();
    t_contlen();
    chk(r6_viol == 0, "R6", "s_ready high while result pending", r6_viol, 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule